// File: doc/BRIEF.md
# Ethernet Transmit Jabber Guard with Manchester Encoder

This block sits between a MAC-side controller and the line driver of a 10 Mb/s Ethernet port. The controller presents NRZ bits on `txd`, qualified by `tx_en`. The block turns them into Manchester symbols on `line_out`. It also hands the raw transmit stream back on a loopback path.

A watchdog counts how long `tx_en` has been held high without a break. If a transmission runs past the limit, the block locks out. While locked out, the line output and the loopback path are both silenced and the `jabber` flag is raised. The lockout lifts only after `tx_en` has been low for an unbroken unjab interval. Any activity during that interval starts the interval over.

When the port is quiet, not locked out and link pulses are enabled, the block sends a one-bit-wide high pulse at a fixed interval. All timers are counted in system clock cycles. The defaults assume a 100 MHz clock: 50 ms for the jabber limit, 500 ms for the unjab interval and 16 ms for the link pulse period.

Top module: `mtx_jabber_guard`

## Requirements
- R1: A half-bit lasts HALF_DIV clocks, and a free-running half-bit phase starts in the first half after reset. At each bit boundary, `tx_en` (gated by the jabber state) and `txd` are captured. While a captured bit is active, `line_out` is the inverse of the bit in the first half and the bit itself in the second half, so a 1 is sent low then high and a 0 is sent high then low.
- R2: `jabber` becomes 1 on the clock edge at which `tx_en` has been sampled high on JAB_LIMIT consecutive edges.
- R3: While `jabber` is 1, `line_active` and `line_out` are both 0.
- R4: `lb_active` equals `tx_en` AND NOT `jabber`, and `lb_rxd` equals `txd` AND `lb_active`. The loopback is therefore silent during lockout.
- R5: `jabber` stays 1 from entry into lockout until release.
- R6: Release happens on the edge at which `tx_en` has been sampled low on UNJAB_LIMIT consecutive edges. A single edge with `tx_en` high during lockout restarts this count from zero.
- R7: When `link_en` is 1, `tx_en` is 0 and the block is not locked out, a link pulse starts every LP_PERIOD clocks, counted from the first quiet edge. Each pulse holds `line_out` at 1 for 2*HALF_DIV clocks, which is one bit time.
- R8: An edge with `tx_en` high, with the block locked out, or with `link_en` low stops any pulse at once and restarts the pulse interval.
- R9: A synchronous active-low reset clears the lockout and all timers. With `tx_en` low, `line_out`, `line_active` and `jabber` are then all 0.
- R10: When no bit is active and no link pulse is in progress, `line_out` rests at 0.
- R11: A burst of JAB_LIMIT-1 edges followed by a low edge does not cause a lockout. The run count starts again after every low edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the controller |
| txd | input | 1 | NRZ transmit data |
| link_en | input | 1 | Enables link integrity pulses |
| line_out | output | 1 | Manchester or link-pulse level to the line driver |
| line_active | output | 1 | High while an encoded bit is being driven |
| lb_active | output | 1 | Loopback qualifier |
| lb_rxd | output | 1 | Loopback data |
| jabber | output | 1 | Lockout status |

## Verification
A wrong watchdog count shows on `jabber` on the edge where the limit is reached, which is one clock early or late. A wrong unjab count shows on the release edge, and a failure to restart the count shows as release well before the interval has run. An error in the half-bit phase or in bit capture shows on `line_out` within one bit time, as a misplaced mid-bit transition. An error in the link pulse counter shows as a shifted or wrongly sized pulse within one LP_PERIOD of the port going quiet. The reference model is compared on every clock, so each of these faults is caught in the cycle it first appears.

// File: rtl/mtx_pkg.sv
// Package: shared types and constants for the transmit jabber guard.
// Assumes: nothing beyond IEEE 1800-2017.
package mtx_pkg;

    // Lockout state of the watchdog
    typedef enum logic {
        JS_OPEN   = 1'b0,
        JS_LOCKED = 1'b1
    } jab_state_e;

    // Resting line level when nothing is sent
    localparam logic LINE_IDLE = 1'b0;

endpackage

// File: rtl/mtx_half_tick.sv
// Module: mtx_half_tick
// Produces a one-clock strobe at the end of every half-bit and a phase flag
// (0 = first half, 1 = second half). Free-running from reset.
// Assumes: HALF_DIV >= 1 clocks per half-bit.
module mtx_half_tick #(
    parameter int HALF_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb,
    output logic ph
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign stb = (cnt == CW'(HALF_DIV - 1));

    // Divide the clock into half-bit periods and toggle the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (stb) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mtx_encoder.sv
// Module: mtx_encoder
// Captures tx_en/txd at each bit boundary and forms the Manchester level:
// first half carries the inverted bit, second half the bit itself.
// Assumes: stb/ph from mtx_half_tick; block is the registered lockout flag.
module mtx_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic ph,
    input  logic tx_en,
    input  logic txd,
    input  logic block,
    output logic act,
    output logic sym
);
    logic dat_q;

    // Capture a new bit when the second half-bit ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            dat_q <= 1'b0;
        end else if (stb && ph) begin
            act   <= tx_en && !block;
            dat_q <= txd;
        end
    end

    // Manchester level from the phase and the captured bit
    always_comb sym = ph ? dat_q : ~dat_q;

    AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !ph && act) |=> (sym != $past(sym))); // R1

endmodule

// File: rtl/mtx_jabber.sv
// Module: mtx_jabber
// Watchdog on continuous tx_en: locks out after JAB_LIMIT high edges,
// releases after UNJAB_LIMIT consecutive low edges; any high edge in
// lockout restarts the idle count.
// Assumes: JAB_LIMIT >= 2, UNJAB_LIMIT >= 2.
module mtx_jabber
    import mtx_pkg::*;
#(
    parameter int JAB_LIMIT   = 5_000_000,
    parameter int UNJAB_LIMIT = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic locked
);
    localparam int RW = $clog2(JAB_LIMIT + 1);
    localparam int IW = $clog2(UNJAB_LIMIT + 1);

    jab_state_e    state;
    logic [RW-1:0] run_cnt;
    logic [IW-1:0] idle_cnt;

    // Track run length while open and idle length while locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= JS_OPEN;
            run_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            case (state)
                JS_OPEN: begin
                    idle_cnt <= '0;
                    if (!tx_en) begin
                        run_cnt <= '0;
                    end else if (run_cnt == RW'(JAB_LIMIT - 1)) begin
                        run_cnt <= '0;
                        state   <= JS_LOCKED;
                    end else begin
                        run_cnt <= run_cnt + 1'b1;
                    end
                end
                default: begin
                    run_cnt <= '0;
                    if (tx_en) begin
                        idle_cnt <= '0;
                    end else if (idle_cnt == IW'(UNJAB_LIMIT - 1)) begin
                        idle_cnt <= '0;
                        state    <= JS_OPEN;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign locked = (state == JS_LOCKED);

    AST_LOCK_ON_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(tx_en)); // R2
    AST_UNLOCK_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !$past(tx_en)); // R6

endmodule

// File: rtl/mtx_link_pulse.sv
// Module: mtx_link_pulse
// While the port is quiet and pulses are enabled, starts a PULSE_LEN-clock
// high pulse every LP_PERIOD clocks; any non-quiet edge clears everything.
// Assumes: LP_PERIOD > PULSE_LEN >= 1.
module mtx_link_pulse #(
    parameter int LP_PERIOD = 1_600_000,
    parameter int PULSE_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok,
    output logic pulse
);
    localparam int LW = $clog2(LP_PERIOD + 1);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [LW-1:0] per_cnt;
    logic [PW-1:0] len_cnt;

    // Interval counter and pulse-width counter
    always_ff @(posedge clk) begin
        if (!rst_n || !ok) begin
            per_cnt <= '0;
            len_cnt <= '0;
        end else if (per_cnt == LW'(LP_PERIOD - 1)) begin
            per_cnt <= '0;
            len_cnt <= PW'(PULSE_LEN);
        end else begin
            per_cnt <= per_cnt + 1'b1;
            if (len_cnt != '0) len_cnt <= len_cnt - 1'b1;
        end
    end

    assign pulse = (len_cnt != '0);

    AST_PULSE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ok |=> !pulse); // R8

endmodule

// File: rtl/mtx_jabber_guard.sv
// Module: mtx_jabber_guard (top)
// Manchester transmit path with jabber lockout, loopback gating and link
// integrity pulses. Timers are in system clock cycles.
// Assumes: defaults sized for a 100 MHz clock (HALF_DIV = 5).
module mtx_jabber_guard
    import mtx_pkg::*;
#(
    parameter int HALF_DIV    = 5,
    parameter int JAB_LIMIT   = 5_000_000,
    parameter int UNJAB_LIMIT = 50_000_000,
    parameter int LP_PERIOD   = 1_600_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic txd,
    input  logic link_en,
    output logic line_out,
    output logic line_active,
    output logic lb_active,
    output logic lb_rxd,
    output logic jabber
);
    localparam int PULSE_LEN = 2 * HALF_DIV;

    logic stb, ph, act, sym, locked, pulse, lp_ok;

    mtx_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .stb(stb), .ph(ph)
    );

    mtx_jabber #(.JAB_LIMIT(JAB_LIMIT), .UNJAB_LIMIT(UNJAB_LIMIT)) u_jab (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .locked(locked)
    );

    mtx_encoder u_enc (
        .clk(clk), .rst_n(rst_n), .stb(stb), .ph(ph), .tx_en(tx_en),
        .txd(txd), .block(locked), .act(act), .sym(sym)
    );

    // Link pulses only on a quiet, unlocked, enabled port
    always_comb lp_ok = link_en && !tx_en && !locked;

    mtx_link_pulse #(.LP_PERIOD(LP_PERIOD), .PULSE_LEN(PULSE_LEN)) u_lp (
        .clk(clk), .rst_n(rst_n), .ok(lp_ok), .pulse(pulse)
    );

    // Output selection: encoded data, else link pulse, else idle level
    always_comb begin
        line_active = act && !locked;
        line_out    = line_active ? sym : (pulse | LINE_IDLE);
        lb_active   = tx_en && !locked;
        lb_rxd      = txd && lb_active;
        jabber      = locked;
    end

    AST_JAB_MUTES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> (!line_out && !line_active)); // R3
    AST_JAB_MUTES_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        jabber |-> (!lb_active && !lb_rxd)); // R4

endmodule

// File: tb/mtx_jabber_guard_tb.sv
module mtx_jabber_guard_tb;
    localparam int HD  = 2;
    localparam int JL  = 120;
    localparam int UL  = 200;
    localparam int LPP = 60;
    localparam int PL  = 2 * HD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, txd = 1'b0, link_en = 1'b0;
    logic line_out, line_active, lb_active, lb_rxd, jabber;

    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mtx_jabber_guard #(.HALF_DIV(HD), .JAB_LIMIT(JL), .UNJAB_LIMIT(UL),
                       .LP_PERIOD(LPP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .link_en(link_en),
        .line_out(line_out), .line_active(line_active), .lb_active(lb_active),
        .lb_rxd(lb_rxd), .jabber(jabber)
    );

    // Behavioural reference state
    int m_hc, m_ph, m_act, m_dat, m_run, m_jab, m_idle, m_lp, m_pc;
    bit m_valid = 0;

    always @(posedge clk) begin
        int stb, ok;
        if (!rst_n) begin
            m_hc = 0; m_ph = 0; m_act = 0; m_dat = 0; m_run = 0;
            m_jab = 0; m_idle = 0; m_lp = 0; m_pc = 0; m_valid = 1;
        end else begin
            stb = (m_hc == HD - 1);
            ok  = link_en && !tx_en && !m_jab;
            if (stb && m_ph == 1) begin
                m_act = tx_en && !m_jab;
                m_dat = txd;
            end
            if (!ok) begin
                m_lp = 0; m_pc = 0;
            end else if (m_lp == LPP - 1) begin
                m_lp = 0; m_pc = PL;
            end else begin
                m_lp++;
                if (m_pc > 0) m_pc--;
            end
            if (!m_jab) begin
                if (tx_en) m_run++; else m_run = 0;
                if (m_run == JL) begin m_jab = 1; m_run = 0; m_idle = 0; end
            end else begin
                if (tx_en) m_idle = 0; else m_idle++;
                if (m_idle == UL) begin m_jab = 0; m_idle = 0; end
            end
            if (stb) begin m_hc = 0; m_ph = 1 - m_ph; end else m_hc++;
        end
    end

    task automatic chk(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference model
    task automatic compare();
        logic e_la, e_lo, e_lba;
        if (!m_valid) return;
        e_la  = m_act && !m_jab;
        e_lo  = e_la ? (m_ph ? m_dat : !m_dat) : (m_pc != 0);
        e_lba = tx_en && !m_jab;
        chk("R1 line_out", line_out, e_lo);
        chk("R3 line_active", line_active, e_la);
        chk("R4 lb_active", lb_active, e_lba);
        chk("R4 lb_rxd", lb_rxd, txd && e_lba);
        chk("R5 jabber", jabber, m_jab[0]);
    endtask

    task automatic cyc(input logic en, input logic d);
        @(negedge clk);
        tx_en = en; txd = d;
        #1 compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int rise_t[$];
        int hi, t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset line_out", line_out, 1'b0);
        chk("R9 reset line_active", line_active, 1'b0);
        chk("R9 reset jabber", jabber, 1'b0);
        rst_n = 1'b1;

        // Frame with mixed data, link pulses enabled
        link_en = 1'b1;
        for (int i = 0; i < 40; i++) cyc(1'b1, logic'((i ^ (i >> 2)) & 1));
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0);

        // R7: pulse timing after the port goes quiet
        t = 0; hi = 0;
        for (int i = 1; i <= 3 * LPP + 2; i++) begin
            cyc(1'b0, 1'b0);
            if (!line_active && line_out) begin
                if (hi == 0) rise_t.push_back(i - 1);
                hi++;
            end else if (hi != 0) begin
                chk("R7 pulse width", logic'(hi == PL), 1'b1);
                hi = 0;
            end
        end
        chk("R7 first pulse at LP_PERIOD", logic'(rise_t.size() > 0 && rise_t[0] == LPP), 1'b1);
        chk("R7 period", logic'(rise_t.size() == 3 && rise_t[1] - rise_t[0] == LPP), 1'b1);

        // R8/R10: no pulses with link disabled, line rests at 0
        link_en = 1'b0;
        hi = 0;
        for (int i = 0; i < 2 * LPP; i++) begin
            cyc(1'b0, 1'b0);
            if (line_out) hi++;
        end
        chk("R8 no pulse when disabled", logic'(hi == 0), 1'b1);
        chk("R10 idle level", line_out, 1'b0);
        link_en = 1'b1;

        // R11: burst one edge short of the limit
        for (int i = 0; i < JL - 1; i++) cyc(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
        chk("R11 short burst no lockout", jabber, 1'b0);

        // R2: exact lockout edge
        for (int i = 1; i <= JL + 1; i++) begin
            cyc(1'b1, logic'(i & 1));
            if (i == JL) chk("R2 before limit", jabber, 1'b0);
            if (i == JL + 1) chk("R2 at limit", jabber, 1'b1);
        end
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1);
        chk("R3 line muted", line_out, 1'b0);
        chk("R4 loopback muted", lb_active, 1'b0);

        // R6: interrupted idle restarts the unjab count
        for (int i = 0; i < UL - 10; i++) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int i = 1; i <= UL + 1; i++) begin
            cyc(1'b0, 1'b0);
            if (i == 20) chk("R6 restart holds lockout", jabber, 1'b1);
            if (i == 20) chk("R8 no pulse in lockout", line_out, 1'b0);
            if (i == UL) chk("R6 still locked", jabber, 1'b1);
            if (i == UL + 1) chk("R6 released", jabber, 1'b0);
        end
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0);
        chk("R4 loopback after release", lb_active, 1'b1);

        // R9: reset during lockout
        for (int i = 0; i < JL + 5; i++) cyc(1'b1, 1'b1);
        chk("R5 locked again", jabber, 1'b1);
        @(negedge clk); rst_n = 1'b0; tx_en = 1'b0;
        @(negedge clk);
        chk("R9 reset clears jabber", jabber, 1'b0);
        chk("R9 reset clears line", line_out, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule